// File: doc/BRIEF.md
# Horizontal Raster Timing Generator

This block produces the horizontal timing of a character-based video controller. It runs on the character clock and keeps a running character-position count. When the count equals a programmable line total, a new raster line starts. Two set/clear windows are built from equality compares against that count. The first gives horizontal blanking. The second gives the active-display window, which is then gated by blanking.

A light-pen strobe stores the horizontal position of the pen. The stored value is the count at the strobe plus a fixed character offset. Only the first strobe is kept. Further strobes are ignored until software clears the valid flag.

All programmable values are plain inputs and are compared every clock. A change therefore applies at the next match. A value that the count never reaches leaves the related output at its present level.

Top module: `htiming_gen`

## Requirements
- R1: After reset, `cnt_o` is 0, `hblank_o` is 1, and `disp_en_o`, `newline_o`, `pen_valid_o` and `pen_x_o` are all 0.
- R2: `cnt_o` rises by one each clock. In the clock after it equals `htotal_i`, it reads 0, so a line lasts `htotal_i`+1 clocks.
- R3: `newline_o` is high for exactly one clock, the first clock in which `cnt_o` reads 0 after a wrap. It is not raised by reset alone.
- R4: `hblank_o` goes to 1 in the clock after `cnt_o` equals `hblank_start_i`. It goes to 0 in the clock after `cnt_o` equals `hblank_end_i`. When both values match at once, going to 1 wins.
- R5: An internal display window goes to 1 in the clock after `cnt_o` equals `de_begin_i`, and to 0 in the clock after `cnt_o` equals `de_end_i`. `disp_en_o` is that window ANDed with NOT `hblank_o`.
- R6: If `de_begin_i` is moved to a position inside blanking, the active area does not start earlier than the end of blanking.
- R7: A strobe on `pen_strobe_i` while `pen_valid_o` is 0 loads `pen_x_o` with (`cnt_o` + 7) mod 2^CW and sets `pen_valid_o` from the next clock on.
- R8: While `pen_valid_o` is 1, further strobes leave `pen_x_o` unchanged.
- R9: `pen_clear_i` makes `pen_valid_o` 0 in the next clock. It takes priority over a strobe in the same clock, and that strobe is then not captured.
- R10: A new compare value applies at its next match. A value that is never reached leaves the related output at its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous reset, active high |
| htotal_i | input | CW | Last count value of a line |
| hblank_start_i | input | CW | Count at which blanking turns on |
| hblank_end_i | input | CW | Count at which blanking turns off |
| de_begin_i | input | CW | Count at which the display window opens |
| de_end_i | input | CW | Count at which the display window closes |
| pen_strobe_i | input | 1 | Light-pen trigger, sampled each clock |
| pen_clear_i | input | 1 | Clears the pen-valid flag |
| cnt_o | output | CW | Running character position |
| hblank_o | output | 1 | Horizontal blanking |
| disp_en_o | output | 1 | Active display enable |
| newline_o | output | 1 | One-clock pulse at the start of a line |
| pen_x_o | output | CW | Captured pen position |
| pen_valid_o | output | 1 | A pen position is held |

## Verification
Line length is measured with two different totals, and the total is changed in the middle of a run. This separates a counter that reloads on the compare from one that runs to a fixed limit.

Blanking and display are checked position by position over a whole line. The cases cover:
- a blanking window that wraps past the line end;
- a display window inside the active area;
- display-begin values inside blanking, which must all give the same left edge;
- unreachable compare values;
- equal set and clear values, which show the set-wins priority.

The pen is strobed in mid-line and next to the counter's width limit, so that the offset must wrap. It is also strobed again while a position is held, and strobed together with a clear.

// File: rtl/htg_pkg.sv
package htg_pkg;
   localparam int unsigned HTG_CW_DEF      = 8;
   localparam int unsigned HTG_PEN_OFS_DEF = 7;
   localparam int unsigned HTG_NUM_WIN     = 2;

   typedef enum int unsigned {
      WIN_BLANK = 0,
      WIN_DISP  = 1
   } htg_win_e;
endpackage

// File: rtl/htg_char_counter.sv
module htg_char_counter #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [CW-1:0] htotal_i,
   output logic [CW-1:0] cnt_o,
   output logic          newline_o
);
   logic [CW-1:0] cnt_q;
   logic          nl_q;
   logic          at_end;

   assign at_end = (cnt_q == htotal_i);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         nl_q  <= 1'b0;
      end else begin
         cnt_q <= at_end ? '0 : cnt_q + 1'b1;
         nl_q  <= at_end;
      end
   end

   assign cnt_o     = cnt_q;
   assign newline_o = nl_q;
endmodule

// File: rtl/htg_window.sv
module htg_window #(
   parameter int unsigned CW      = 8,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [CW-1:0] cnt_i,
   input  logic [CW-1:0] on_i,
   input  logic [CW-1:0] off_i,
   output logic          win_o
);
   logic win_q;

   always_ff @(posedge clk) begin
      if (rst)                win_q <= RST_VAL;
      else if (cnt_i == on_i)  win_q <= 1'b1;
      else if (cnt_i == off_i) win_q <= 1'b0;
   end

   assign win_o = win_q;
endmodule

// File: rtl/htg_pen_latch.sv
module htg_pen_latch #(
   parameter int unsigned CW  = 8,
   parameter int unsigned OFS = 7
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [CW-1:0] cnt_i,
   input  logic          strobe_i,
   input  logic          clear_i,
   output logic [CW-1:0] pen_x_o,
   output logic          valid_o
);
   localparam logic [CW-1:0] OFS_C = CW'(OFS);

   logic [CW-1:0] target;
   logic [CW-1:0] x_q;
   logic          v_q;

   if (OFS == 0) begin : g_raw
      assign target = cnt_i;
   end else begin : g_ofs
      assign target = cnt_i + OFS_C;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         x_q <= '0;
         v_q <= 1'b0;
      end else if (clear_i) begin
         v_q <= 1'b0;
      end else if (strobe_i && !v_q) begin
         x_q <= target;
         v_q <= 1'b1;
      end
   end

   assign pen_x_o = x_q;
   assign valid_o = v_q;
endmodule

// File: rtl/htiming_gen.sv
module htiming_gen #(
   parameter int unsigned CW      = htg_pkg::HTG_CW_DEF,
   parameter int unsigned PEN_OFS = htg_pkg::HTG_PEN_OFS_DEF
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [CW-1:0] htotal_i,
   input  logic [CW-1:0] hblank_start_i,
   input  logic [CW-1:0] hblank_end_i,
   input  logic [CW-1:0] de_begin_i,
   input  logic [CW-1:0] de_end_i,
   input  logic          pen_strobe_i,
   input  logic          pen_clear_i,
   output logic [CW-1:0] cnt_o,
   output logic          hblank_o,
   output logic          disp_en_o,
   output logic          newline_o,
   output logic [CW-1:0] pen_x_o,
   output logic          pen_valid_o
);
   import htg_pkg::*;

   localparam int unsigned NWIN = HTG_NUM_WIN;

   if (CW < 4 || CW > 16) begin : g_bad_cw
      $error("htiming_gen: CW must lie in 4..16");
   end
   if (PEN_OFS >= (1 << CW)) begin : g_bad_ofs
      $error("htiming_gen: PEN_OFS must fit in CW bits");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] on_val  [NWIN];
   logic [CW-1:0] off_val [NWIN];
   logic          win     [NWIN];

   htg_char_counter #(.CW(CW)) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .htotal_i  (htotal_i),
      .cnt_o     (cnt),
      .newline_o (newline_o)
   );

   assign on_val[WIN_BLANK]  = hblank_start_i;
   assign off_val[WIN_BLANK] = hblank_end_i;
   assign on_val[WIN_DISP]   = de_begin_i;
   assign off_val[WIN_DISP]  = de_end_i;

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      htg_window #(
         .CW      (CW),
         .RST_VAL (w == WIN_BLANK)
      ) u_win (
         .clk   (clk),
         .rst   (rst),
         .cnt_i (cnt),
         .on_i  (on_val[w]),
         .off_i (off_val[w]),
         .win_o (win[w])
      );
   end

   htg_pen_latch #(.CW(CW), .OFS(PEN_OFS)) u_pen (
      .clk      (clk),
      .rst      (rst),
      .cnt_i    (cnt),
      .strobe_i (pen_strobe_i),
      .clear_i  (pen_clear_i),
      .pen_x_o  (pen_x_o),
      .valid_o  (pen_valid_o)
   );

   assign cnt_o     = cnt;
   assign hblank_o  = win[WIN_BLANK];
   assign disp_en_o = win[WIN_DISP] & ~win[WIN_BLANK];
endmodule

// File: rtl/htiming_gen_chk.sv
module htiming_gen_chk #(
   parameter int unsigned CW      = 8,
   parameter int unsigned PEN_OFS = 7
) (
   input logic          clk,
   input logic          rst,
   input logic [CW-1:0] htotal_i,
   input logic [CW-1:0] hblank_start_i,
   input logic          pen_clear_i,
   input logic [CW-1:0] cnt_o,
   input logic          hblank_o,
   input logic          disp_en_o,
   input logic          newline_o,
   input logic [CW-1:0] pen_x_o,
   input logic          pen_valid_o
);
   // R2
   cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (cnt_o == htotal_i) |=> (cnt_o == '0));
   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
      (cnt_o != htotal_i) |=> (cnt_o == CW'($past(cnt_o) + 1'b1)));
   // R3
   newline_zero_chk: assert property (@(posedge clk) disable iff (rst)
      newline_o |-> (cnt_o == '0));
   // R4
   blank_on_chk: assert property (@(posedge clk) disable iff (rst)
      (cnt_o == hblank_start_i) |=> hblank_o);
   // R5
   disp_gated_chk: assert property (@(posedge clk) disable iff (rst)
      hblank_o |-> !disp_en_o);
   // R7
   pen_load_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(pen_valid_o) |-> (pen_x_o == CW'($past(cnt_o) + PEN_OFS)));
   // R8
   pen_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (pen_valid_o && !pen_clear_i) |=> (pen_valid_o && $stable(pen_x_o)));
   // R9
   pen_clear_chk: assert property (@(posedge clk) disable iff (rst)
      pen_clear_i |=> !pen_valid_o);
endmodule

bind htiming_gen htiming_gen_chk #(.CW(CW), .PEN_OFS(PEN_OFS)) u_chk (
   .clk            (clk),
   .rst            (rst),
   .htotal_i       (htotal_i),
   .hblank_start_i (hblank_start_i),
   .pen_clear_i    (pen_clear_i),
   .cnt_o          (cnt_o),
   .hblank_o       (hblank_o),
   .disp_en_o      (disp_en_o),
   .newline_o      (newline_o),
   .pen_x_o        (pen_x_o),
   .pen_valid_o    (pen_valid_o)
);

// File: tb/htiming_gen_tb_top.sv
module htiming_gen_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [CW-1:0] htotal = 8'd9;
   logic [CW-1:0] hb_start = 8'd200;
   logic [CW-1:0] hb_end = 8'd201;
   logic [CW-1:0] de_begin = 8'd200;
   logic [CW-1:0] de_end = 8'd201;
   logic          pen_strobe = 1'b0;
   logic          pen_clear = 1'b0;
   logic [CW-1:0] cnt;
   logic          hblank, disp_en, newline, pen_valid;
   logic [CW-1:0] pen_x;

   int errs = 0;
   int checks = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   htiming_gen #(.CW(CW), .PEN_OFS(7)) dut_i (
      .clk(clk), .rst(rst), .htotal_i(htotal), .hblank_start_i(hb_start),
      .hblank_end_i(hb_end), .de_begin_i(de_begin), .de_end_i(de_end),
      .pen_strobe_i(pen_strobe), .pen_clear_i(pen_clear), .cnt_o(cnt),
      .hblank_o(hblank), .disp_en_o(disp_en), .newline_o(newline),
      .pen_x_o(pen_x), .pen_valid_o(pen_valid));

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wait_newline();
      do @(negedge clk); while (!newline);
   endtask

   task automatic wait_cnt(input int v);
      do @(negedge clk); while (cnt != CW'(v));
   endtask

   task automatic line_len(output int n);
      wait_newline();
      n = 0;
      do begin @(negedge clk); n++; end while (!newline);
   endtask

   // Check one whole line: the output named by sel against an expected range.
   // sel 0 = hblank_o, sel 1 = disp_en_o. Expected 1 for cnt in [lo..hi]
   // (wrapping when lo > hi); mode 2 = always 0, mode 3 = always 1.
   task automatic check_line(input string req, input int sel, input int mode,
                             input int lo, input int hi);
      int bad = 0, bad_c = 0, bad_a = 0, bad_e = 0;
      wait_newline();
      for (int i = 0; i <= int'(htotal); i++) begin
         int c = int'(cnt);
         int e;
         int a = (sel == 0) ? int'(hblank) : int'(disp_en);
         if (mode == 2) e = 0;
         else if (mode == 3) e = 1;
         else if (lo <= hi) e = (c >= lo && c <= hi) ? 1 : 0;
         else e = (c >= lo || c <= hi) ? 1 : 0;
         if (a != e && bad == 0) begin bad = 1; bad_c = c; bad_a = a; bad_e = e; end
         @(negedge clk);
      end
      chk(bad == 0, req, $sformatf("line profile at cnt=%0d", bad_c), bad_a, bad_e);
   endtask

   task automatic t_reset();
      @(negedge clk); @(negedge clk);
      chk(cnt == 0, "R1", "cnt in reset", cnt, 0);
      chk(hblank == 1'b1, "R1", "hblank in reset", hblank, 1);
      chk(disp_en == 1'b0 && newline == 1'b0, "R1", "de/newline in reset",
          {disp_en, newline}, 0);
      chk(pen_valid == 1'b0 && pen_x == 0, "R1", "pen in reset", pen_x, 0);
      rst = 1'b0;
      @(negedge clk);
      chk(cnt == 1 && newline == 1'b0, "R3", "no newline after reset", newline, 0);
   endtask

   task automatic t_line_length();
      int n;
      line_len(n);
      chk(n == 10, "R2", "line length total=9", n, 10);
      wait_newline();
      htotal = 8'd14;
      line_len(n);
      chk(n == 15, "R2", "line length total=14", n, 15);
      wait_newline();
      @(negedge clk);
      chk(newline == 1'b0, "R3", "newline one clock wide", newline, 0);
   endtask

   task automatic t_blank();
      hb_start = 8'd12; hb_end = 8'd2;
      wait_newline();
      check_line("R4", 0, 0, 13, 2);
   endtask

   task automatic t_display();
      de_begin = 8'd4; de_end = 8'd10;
      wait_newline();
      check_line("R5", 1, 0, 5, 10);
      de_begin = 8'd1;
      wait_newline();
      check_line("R6", 1, 0, 3, 10);
      de_begin = 8'd0;
      wait_newline();
      check_line("R6", 1, 0, 3, 10);
   endtask

   task automatic t_unreached();
      hb_start = 8'd200;
      wait_newline();
      check_line("R10", 0, 2, 0, 0);
      hb_start = 8'd12; hb_end = 8'd200;
      wait_newline();
      check_line("R10", 0, 3, 0, 0);
      hb_start = 8'd200; hb_end = 8'd2;
      wait_newline();
      hb_start = 8'd5; hb_end = 8'd5;
      wait_newline();
      check_line("R4", 0, 3, 0, 0);
      hb_start = 8'd12; hb_end = 8'd2;
   endtask

   task automatic t_pen();
      wait_cnt(5);
      pen_strobe = 1'b1;
      @(negedge clk);
      pen_strobe = 1'b0;
      chk(pen_valid == 1'b1, "R7", "valid after strobe", pen_valid, 1);
      chk(pen_x == 12, "R7", "pen x mid-line", pen_x, 12);
      wait_cnt(9);
      pen_strobe = 1'b1;
      @(negedge clk);
      pen_strobe = 1'b0;
      chk(pen_x == 12 && pen_valid, "R8", "second strobe ignored", pen_x, 12);
      pen_clear = 1'b1;
      @(negedge clk);
      pen_clear = 1'b0;
      chk(pen_valid == 1'b0, "R9", "clear drops valid", pen_valid, 0);
      wait_cnt(10);
      pen_strobe = 1'b1;
      @(negedge clk);
      pen_strobe = 1'b0;
      chk(pen_x == 17, "R7", "pen x after clear", pen_x, 17);
      pen_clear = 1'b1; pen_strobe = 1'b1;
      @(negedge clk);
      pen_clear = 1'b0; pen_strobe = 1'b0;
      @(negedge clk);
      chk(pen_valid == 1'b0 && pen_x == 17, "R9", "clear beats strobe",
          pen_valid, 0);
      htotal = 8'd254;
      wait_cnt(250);
      pen_strobe = 1'b1;
      @(negedge clk);
      pen_strobe = 1'b0;
      chk(pen_x == 1, "R7", "pen x wraps mod 256", pen_x, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_line_length();
      t_blank();
      t_display();
      t_unreached();
      t_pen();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule